// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs accesses on a synchronous external memory bus with a 16-bit data path, one access at a time. A host asks for a transfer with a level request that carries direction, size, byte address and write data. The controller then drives chip select, a read or write strobe, address and write data. Each bus cycle lasts one base cycle plus a programmed number of standard wait states. An active-low wait input from the memory can stretch the bus cycle further.

A 32-bit transfer is split into two 16-bit bus cycles. Each half has its own strobe pulse, its own standard wait count and its own wait extension. Read data is captured at the clock edge that really ends each stretched bus cycle. Strobes stay low for the whole stretched bus cycle and rise together with chip select. The host sees a one-clock acknowledge with the assembled read data. The host drops its request in the acknowledge cycle.

The wait input is only qualified in certain cycles. It counts at the first edge of a bus cycle, at any edge while standard wait states remain, and at every edge of an extension already in progress. Memories that use it must therefore be given enough standard wait states.

Top module: `ebus_wait_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, cs_n, rd_n and we_n are high, bus_oe is low and ack is low until a request is accepted.
- R2: With wait_n high, a bus cycle keeps cs_n low for exactly 1 + ws_cfg clocks. ws_cfg is a 3-bit value from 0 to 7, latched when the request is accepted. ack is high in the clock right after cs_n rises, and cs_n is high in that clock.
- R3: wait_n is sampled at each rising clock edge while cs_n is low. If it is low at the first edge of a bus cycle, at an edge where at least one standard wait state remains, or at an edge that already belongs to a wait extension, the bus cycle lengthens by one clock. That edge does not use up a standard wait state, and address and strobes hold.
- R4: wait_n low at an edge that is not the first edge of the bus cycle, where no standard wait state remains and no extension is running, has no effect. The bus cycle ends at that edge.
- R5: For reads, rd_n is low for every clock in which cs_n is low, except the gap clock of a word transfer. The 16-bit value on bus_din is captured at the final rising edge of the stretched bus cycle.
- R6: For writes of any size, we_n is low for the whole stretched bus cycle and rises in the same clock as cs_n, or as the start of the word gap. bus_oe is high only while cs_n is low during writes. rd_n and we_n are never low together.
- R7: req_size 2 or 3 is a word transfer. It runs two bus cycles, first at the address with bits 1:0 forced to 00 and then with bits 1:0 at 10. Between them is one gap clock with cs_n low and both strobes high, and each half is waited separately. Write data goes out as req_wdata[15:0] in the first bus cycle and req_wdata[31:16] in the second. Read data returns as {second half-word, first half-word}.
- R8: req_size 0 (byte) and 1 (half-word) take a single bus cycle at req_addr. A byte read returns bus_din[15:8] when req_addr[0] is 1 and bus_din[7:0] when it is 0, zero-extended. A half-word read returns bus_din zero-extended. A byte write drives the byte on both lanes of bus_dout.
- R9: A request is accepted only in the idle state and not in the acknowledge clock. At least one clock with cs_n high separates consecutive accesses.
- R10: ack is high for exactly one clock per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all logic on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request level, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| req_addr | input | ADDR_W | Byte address of the transfer |
| req_wdata | input | 32 | Write data, low bits used for narrow writes |
| ws_cfg | input | WS_W | Number of standard wait states |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Read result, valid with ack |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| we_n | output | 1 | Active-low write strobe |
| bus_addr | output | ADDR_W | External byte address |
| bus_dout | output | 16 | External write data |
| bus_oe | output | 1 | Write data drive enable |
| bus_din | input | 16 | External read data |
| wait_n | input | 1 | Active-low wait request from memory |

## Verification
The assertions take for granted that wait_n and bus_din are synchronous to clk. They also take for granted that the host keeps req and its fields stable until ack and drops req no later than the clock after ack. Under these conditions, a stall must hold address and strobes, and no new chip-select pulse can begin next to an acknowledge. The stimulus keeps within these rules. All host inputs change only at falling edges. The memory model drives wait_n and bus_din at falling edges, from a per-vector wait mask indexed by the number of clocks since chip select fell. In one directed case the request is held through the acknowledge clock, to test that it is not accepted again there.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WORD_ALT = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_STROBE = 2'd1,
    PH_GAP    = 2'd2
  } phase_e;

  // A word transfer is split into two half-word bus cycles (R7)
  function automatic logic is_split(input xfer_size_e sz);
    return sz[1];
  endfunction

  // Write lane placement (R7, R8)
  function automatic logic [15:0] lane_out(input xfer_size_e sz, input logic upper,
                                           input logic [31:0] wd);
    case (sz)
      SZ_BYTE: lane_out = {2{wd[7:0]}};
      SZ_HALF: lane_out = wd[15:0];
      default: lane_out = upper ? wd[31:16] : wd[15:0];
    endcase
  endfunction

  // Read result assembly (R7, R8)
  function automatic logic [31:0] read_merge(input xfer_size_e sz, input logic a0,
                                             input logic [15:0] lo, input logic [15:0] din);
    case (sz)
      SZ_BYTE: read_merge = {24'h0, (a0 ? din[15:8] : din[7:0])};
      SZ_HALF: read_merge = {16'h0, din};
      default: read_merge = {din, lo};
    endcase
  endfunction

endpackage

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            split,
  input  logic [WS_W-1:0] ws,
  input  logic            wait_n,
  output phase_e          phase,
  output logic            upper,
  output logic            stall,
  output logic            cyc_end,
  output logic            xfer_end
);

  localparam logic [WS_W-1:0] WS_ZERO = '0;
  localparam logic [WS_W-1:0] WS_ONE  = {{(WS_W-1){1'b0}}, 1'b1};

  logic [WS_W-1:0] rem_q;
  logic [WS_W-1:0] ws_q;
  logic            first_q;
  logic            ext_q;
  logic            split_q;

  // wait qualifies at first edge, while standard waits remain, or inside an extension (R3, R4)
  assign stall    = (phase == PH_STROBE) && !wait_n && (first_q || (rem_q != WS_ZERO) || ext_q);
  assign cyc_end  = (phase == PH_STROBE) && !stall && (rem_q == WS_ZERO);
  assign xfer_end = cyc_end && (!split_q || upper);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      upper   <= 1'b0;
      rem_q   <= WS_ZERO;
      ws_q    <= WS_ZERO;
      first_q <= 1'b0;
      ext_q   <= 1'b0;
      split_q <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_STROBE;
            upper   <= 1'b0;
            rem_q   <= ws;
            ws_q    <= ws;
            first_q <= 1'b1;
            ext_q   <= 1'b0;
            split_q <= split;
          end
        end
        PH_STROBE: begin
          first_q <= 1'b0;
          if (stall) begin
            ext_q <= 1'b1;
          end else begin
            ext_q <= 1'b0;
            if (rem_q != WS_ZERO) rem_q <= rem_q - WS_ONE;
            else if (split_q && !upper) phase <= PH_GAP;
            else phase <= PH_IDLE;
          end
        end
        PH_GAP: begin
          phase   <= PH_STROBE;
          upper   <= 1'b1;
          rem_q   <= ws_q;
          first_q <= 1'b1;
          ext_q   <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ebus_path.sv
module ebus_path
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_wr,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              upper,
  input  logic              cyc_end,
  input  logic              xfer_end,
  input  logic [15:0]       bus_din,
  output logic              op_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_dout,
  output logic [31:0]       rdata,
  output logic              ack
);

  xfer_size_e        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wdata_q;
  logic [15:0]       lo_q;

  assign bus_addr = is_split(size_q) ? {addr_q[ADDR_W-1:2], upper, 1'b0} : addr_q;
  assign bus_dout = lane_out(size_q, upper, wdata_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_wr   <= 1'b0;
      size_q  <= SZ_BYTE;
      addr_q  <= '0;
      wdata_q <= '0;
      lo_q    <= '0;
      rdata   <= '0;
      ack     <= 1'b0;
    end else begin
      ack <= xfer_end;
      if (start) begin
        op_wr   <= req_wr;
        size_q  <= xfer_size_e'(req_size);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      // sample at the true end of each stretched bus cycle (R5)
      if (cyc_end && !op_wr && !upper) lo_q <= bus_din;
      if (xfer_end && !op_wr) rdata <= read_merge(size_q, addr_q[0], lo_q, bus_din);
    end
  end

endmodule

// File: rtl/ebus_wait_ctrl.sv
module ebus_wait_ctrl
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [WS_W-1:0]   ws_cfg,
  output logic              ack,
  output logic [31:0]       rdata,
  output logic              cs_n,
  output logic              rd_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_dout,
  output logic              bus_oe,
  input  logic [15:0]       bus_din,
  input  logic              wait_n
);

  phase_e phase;
  logic   upper;
  logic   stall;
  logic   cyc_end;
  logic   xfer_end;
  logic   op_wr;
  logic   start;
  logic   in_gap;

  // accepted only when idle and outside the ack clock (R9)
  assign start  = req && (phase == PH_IDLE) && !ack;
  assign in_gap = (phase == PH_GAP);

  ebus_seq #(.WS_W(WS_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .split    (is_split(xfer_size_e'(req_size))),
    .ws       (ws_cfg),
    .wait_n   (wait_n),
    .phase    (phase),
    .upper    (upper),
    .stall    (stall),
    .cyc_end  (cyc_end),
    .xfer_end (xfer_end)
  );

  ebus_path #(.ADDR_W(ADDR_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_wr    (req_wr),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .upper     (upper),
    .cyc_end   (cyc_end),
    .xfer_end  (xfer_end),
    .bus_din   (bus_din),
    .op_wr     (op_wr),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .rdata     (rdata),
    .ack       (ack)
  );

  assign cs_n   = (phase == PH_IDLE);
  assign rd_n   = !((phase == PH_STROBE) && !op_wr);
  assign we_n   = !((phase == PH_STROBE) && op_wr);
  assign bus_oe = op_wr && (phase != PH_IDLE);

endmodule

// File: rtl/ebus_wait_chk.sv
module ebus_wait_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              we_n,
  input logic              bus_oe,
  input logic              ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              stall,
  input logic              in_gap
);

  assert_strobe_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !we_n) |-> !cs_n);

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> we_n);

  assert_we_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (cs_n || in_gap));

  assert_oe_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !cs_n);

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!cs_n && $stable(bus_addr) && $stable(rd_n) && $stable(we_n)));

  assert_gap_then_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |=> (!cs_n && (!rd_n || !we_n)));

  assert_ack_after_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (cs_n && $past(!cs_n)));

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_idle_sep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(ack));

endmodule

bind ebus_wait_ctrl ebus_wait_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .rd_n     (rd_n),
  .we_n     (we_n),
  .bus_oe   (bus_oe),
  .ack      (ack),
  .bus_addr (bus_addr),
  .stall    (stall),
  .in_gap   (in_gap)
);

// File: tb/tb_ebus_wait_ctrl.sv
module tb_ebus_wait_ctrl;

  localparam int ADDR_W = 24;
  localparam int WS_W   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic              req_wr = 1'b0;
  logic [1:0]        req_size = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic [WS_W-1:0]   ws_cfg = '0;
  logic              ack;
  logic [31:0]       rdata;
  logic              cs_n, rd_n, we_n, bus_oe;
  logic [ADDR_W-1:0] bus_addr;
  logic [15:0]       bus_dout;
  logic [15:0]       bus_din = 16'h0;
  logic              wait_n = 1'b1;

  ebus_wait_ctrl #(.ADDR_W(ADDR_W), .WS_W(WS_W)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .ws_cfg(ws_cfg), .ack(ack),
    .rdata(rdata), .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din), .wait_n(wait_n)
  );

  initial forever #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // memory model state, updated at falling edges
  logic [15:0]       mask = 16'h0;
  int                k = 0;
  bit                started = 0;
  int                cs_cnt = 0;
  int                stb_cnt = 0;
  int                oe_bad = 0;
  bit                seen_we = 0;
  bit                seen_cs = 0;
  logic [15:0]       first_dout = '0, last_dout = '0;
  logic [ADDR_W-1:0] first_addr = '0, last_addr = '0;

  initial begin
    forever begin
      @(negedge clk);
      if (!cs_n) begin
        k = started ? k + 1 : 0;
        started = 1;
        cs_cnt++;
        if (!rd_n || !we_n) stb_cnt++;
        if (bus_oe != req_wr) oe_bad++;
        if (!we_n) begin
          if (!seen_we) first_dout = bus_dout;
          last_dout = bus_dout;
          seen_we = 1;
        end
        if (!seen_cs) first_addr = bus_addr;
        last_addr = bus_addr;
        seen_cs = 1;
      end else begin
        started = 0;
        if (bus_oe) oe_bad++;
      end
      wait_n  = !(started && k < 16 && mask[k]);
      bus_din = 16'hC000 + 16'(k);
    end
  end

  logic [31:0] got_rd;
  int          got_cs, got_stb;

  // one access: wait mask indexed by clocks since cs_n fell
  task automatic run(input logic wr, input logic [1:0] sz, input logic [2:0] ws,
                     input logic [23:0] addr, input logic [31:0] wd,
                     input logic [15:0] m, input bit hold);
    int n;
    @(negedge clk);
    req_wr = wr; req_size = sz; ws_cfg = ws; req_addr = addr; req_wdata = wd;
    mask = m; cs_cnt = 0; stb_cnt = 0; oe_bad = 0; seen_we = 0; seen_cs = 0;
    req = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ack && n < 100);
    check("R2 ack arrives", {31'h0, ack}, 32'h1);
    check("R2 cs_n high in ack clock", {31'h0, cs_n}, 32'h1);
    got_rd = rdata; got_cs = cs_cnt; got_stb = stb_cnt;
    if (!hold) req = 1'b0;
    @(negedge clk);
    check("R10 ack one clock", {31'h0, ack}, 32'h0);
    check("R9 no restart from ack clock", {31'h0, cs_n}, 32'h1);
    check("R6 bus_oe only in write cs", oe_bad, 0);
    req = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [2:0]  ws;
    logic [23:0] addr;
    logic [15:0] m;
    logic [7:0]  cs_len;
    logic [7:0]  stb_len;
    logic        chk;
    logic [31:0] rd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd1, 3'd0, 24'h10, 16'h0000, 8'd1, 8'd1, 1'b1, 32'h0000C000, 4'd2}, // R2
    '{1'b0, 2'd1, 3'd2, 24'h10, 16'h0000, 8'd3, 8'd3, 1'b1, 32'h0000C002, 4'd2}, // R2
    '{1'b0, 2'd1, 3'd0, 24'h10, 16'h0003, 8'd3, 8'd3, 1'b1, 32'h0000C002, 4'd3}, // R3 first edge
    '{1'b0, 2'd1, 3'd1, 24'h10, 16'h0002, 8'd2, 8'd2, 1'b1, 32'h0000C001, 4'd4}, // R4 ignored
    '{1'b0, 2'd1, 3'd2, 24'h10, 16'h0002, 8'd4, 8'd4, 1'b1, 32'h0000C003, 4'd5}, // R5 sample late
    '{1'b0, 2'd2, 3'd1, 24'h10, 16'h0000, 8'd5, 8'd4, 1'b1, 32'hC004C001, 4'd7}, // R7 word
    '{1'b0, 2'd2, 3'd1, 24'h10, 16'h0008, 8'd6, 8'd5, 1'b1, 32'hC005C001, 4'd7}, // R7 upper waited
    '{1'b0, 2'd3, 3'd2, 24'h10, 16'h0003, 8'd9, 8'd8, 1'b1, 32'hC008C004, 4'd7}, // R7 lower waited
    '{1'b1, 2'd1, 3'd1, 24'h10, 16'h0002, 8'd2, 8'd2, 1'b0, 32'h0,       4'd4}, // R4 write
    '{1'b1, 2'd1, 3'd2, 24'h10, 16'h0006, 8'd5, 8'd5, 1'b0, 32'h0,       4'd6}, // R6 write stretch
    '{1'b1, 2'd2, 3'd0, 24'h10, 16'h0001, 8'd4, 8'd3, 1'b0, 32'h0,       4'd6}, // R6 word write
    '{1'b0, 2'd0, 3'd0, 24'h11, 16'h0000, 8'd1, 8'd1, 1'b1, 32'h000000C0, 4'd8}, // R8 odd byte
    '{1'b0, 2'd0, 3'd1, 24'h10, 16'h0000, 8'd2, 8'd2, 1'b1, 32'h00000001, 4'd8}  // R8 even byte
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cs_n in reset", {31'h0, cs_n}, 32'h1);
    check("R1 strobes in reset", {30'h0, rd_n, we_n}, 32'h3);
    check("R1 ack/oe in reset", {30'h0, ack, bus_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {29'h0, cs_n, rd_n, we_n}, 32'h7);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].wr, VECS[i].sz, VECS[i].ws, VECS[i].addr, 32'h1234ABCD, VECS[i].m, 0);
      check($sformatf("R%0d cs length vec %0d", VECS[i].rq, i), got_cs, 32'(VECS[i].cs_len));
      check($sformatf("R%0d strobe length vec %0d", VECS[i].rq, i), got_stb, 32'(VECS[i].stb_len));
      if (VECS[i].chk)
        check($sformatf("R%0d read data vec %0d", VECS[i].rq, i), got_rd, VECS[i].rd);
    end

    // R7 word write lanes and addresses
    run(1'b1, 2'd2, 3'd1, 24'h000123, 32'h5566A1B2, 16'h0, 0);
    check("R7 word write first half", {16'h0, first_dout}, 32'h0000A1B2);
    check("R7 word write second half", {16'h0, last_dout}, 32'h00005566);
    check("R7 word first address", {8'h0, first_addr}, 32'h00000120);
    check("R7 word second address", {8'h0, last_addr}, 32'h00000122);

    // R8 byte write replicates lanes, keeps its address
    run(1'b1, 2'd0, 3'd0, 24'h000045, 32'hFFFFFF5A, 16'h0, 0);
    check("R8 byte write lanes", {16'h0, first_dout}, 32'h00005A5A);
    check("R8 byte address", {8'h0, first_addr}, 32'h00000045);

    // R9 request held through the ack clock is not taken again
    run(1'b0, 2'd1, 3'd0, 24'h10, 32'h0, 16'h0, 1);
    check("R9 still idle", {31'h0, cs_n}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule